// File: doc/BRIEF.md
# Priority Bus Arbiter

This block decides which of eight bus masters may use one shared slave port. A master's request counts only when its address selects this slave, which the top four address bits do. A 16-bit configuration word gives every master one of four priority levels. Among the qualified requesters, the highest level present wins. When several masters share that level, the grant rotates among them, starting just after the master that was granted last.

The grant is registered. It stays with the winning master for its whole bus cycle, bursts included, and it clears once that master lowers its cycle-active line. At least one clock with no grant always passes before the next grant. The configuration word is read only when a new grant is decided, so changing it during a grant has no effect on that grant. All pins are plain level signals. The grant is a one-clock-late decision, and it has no valid/ready exchange. The index of this slave is the parameter `SLAVE_ID`.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset, `grant` is 0 and `grant_valid` is 0. The rotation start is master 0, so the first tie among equal levels goes to the lowest-numbered pending master.
- R2: Master i's request counts only when `mst_req[i]` is 1 and bits [31:28] of its address slice `mst_addr[32*i+31 : 32*i]` equal `SLAVE_ID`. Any other request is ignored.
- R3: Master i's level is `prio_word[2*i+1 : 2*i]`. The pending master with the numerically highest level is granted.
- R4: Among pending masters at the highest level, the grant goes to the first one found when counting upward, with wrap-around, from the index after the last granted master.
- R5: While the granted master holds `mst_cyc` high, `grant` does not change, whatever the other requests do.
- R6: At the first rising edge where the granted master's `mst_cyc` is low, `grant` clears. A new grant can come no earlier than the following edge, so at least one clock has no grant.
- R7: A change to `prio_word` during a grant leaves that grant unchanged. The new word is used at the next decision.
- R8: `grant` is one-hot or zero, and `grant_valid` is 1 exactly when `grant` is nonzero.
- R9: When no grant is held and a qualified request is present at a rising edge, the chosen master's grant bit is high right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_req | input | 8 | Request line for each master |
| mst_cyc | input | 8 | Cycle-active line for each master |
| mst_addr | input | 256 | Address for each master, 32 bits per master, master i in bits [32*i+31:32*i] |
| prio_word | input | 16 | Packed levels, 2 bits per master |
| grant | output | 8 | One-hot grant |
| grant_valid | output | 1 | High while a grant is held |

## Verification
Every result becomes visible one rising edge after the inputs that cause it. A new grant appears at the edge where an idle arbiter sees a qualified request. A grant clears at the edge where the granted master's cycle line is seen low. The bench changes inputs only on falling edges. It steps its reference model at each rising edge using the inputs present at that edge. At the following falling edge it compares `grant` and `grant_valid` with the model. The directed cases release the granted master and then expect zero for one clock and the next winner on the clock after that.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned ARB_MASTERS = 8;
  localparam int unsigned ARB_PRIO_W  = 2;
  localparam int unsigned ARB_ADDR_W  = 32;
  localparam int unsigned ARB_SEL_W   = 4;

  typedef enum logic {ARB_FREE = 1'b0, ARB_HELD = 1'b1} arb_state_e;
endpackage

// File: rtl/arb_req_qual.sv
module arb_req_qual #(
  parameter int unsigned N        = arb_pkg::ARB_MASTERS,
  parameter int unsigned AW       = arb_pkg::ARB_ADDR_W,
  parameter int unsigned SW       = arb_pkg::ARB_SEL_W,
  parameter int unsigned SLAVE_ID = 0
) (
  input  logic [N-1:0]    req,
  input  logic [N*AW-1:0] addr_flat,
  output logic [N-1:0]    qual
);
  localparam int unsigned SEL_LSB = AW - SW;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign qual[i] = req[i] && (addr_flat[i*AW + SEL_LSB +: SW] == SW'(SLAVE_ID));
  end
endmodule

// File: rtl/arb_level_filter.sv
module arb_level_filter #(
  parameter int unsigned N  = arb_pkg::ARB_MASTERS,
  parameter int unsigned PW = arb_pkg::ARB_PRIO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  qual,
  input  logic [N*PW-1:0] prio_word,
  output logic [N-1:0]  cand
);
  logic [PW-1:0] lvl [N];
  logic [PW-1:0] top_lvl;

  for (genvar i = 0; i < N; i++) begin : g_lvl
    assign lvl[i] = prio_word[i*PW +: PW];
  end

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (qual[i] && (lvl[i] > top_lvl)) top_lvl = lvl[i];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_cand
    assign cand[i] = qual[i] && (lvl[i] == top_lvl);
  end

  // R3: a pending request always leaves a candidate, and only pending masters become candidates
  assert_cand_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|qual) |-> (|cand));
  assert_cand_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cand & ~qual) == '0));
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned N  = arb_pkg::ARB_MASTERS,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] start_idx,
  output logic [N-1:0]  pick_oh,
  output logic [IW-1:0] pick_idx,
  output logic          pick_any
);
  logic [IW:0]   pos;
  logic [IW-1:0] slot;

  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    pick_any = 1'b0;
    pos      = '0;
    slot     = '0;
    for (int k = 0; k < N; k++) begin
      pos = {1'b0, start_idx} + (IW+1)'(k);
      if (pos >= (IW+1)'(N)) pos = pos - (IW+1)'(N);
      slot = pos[IW-1:0];
      if (!pick_any && cand[slot]) begin
        pick_any       = 1'b1;
        pick_oh[slot]  = 1'b1;
        pick_idx       = slot;
      end
    end
  end

  // R4: the pick is a single candidate, present whenever any candidate is
  assert_pick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));
  assert_pick_in_cand_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand) |-> ((pick_oh & cand) != '0));
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int unsigned N        = arb_pkg::ARB_MASTERS,
  parameter int unsigned PW       = arb_pkg::ARB_PRIO_W,
  parameter int unsigned AW       = arb_pkg::ARB_ADDR_W,
  parameter int unsigned SW       = arb_pkg::ARB_SEL_W,
  parameter int unsigned SLAVE_ID = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    mst_req,
  input  logic [N-1:0]    mst_cyc,
  input  logic [N*AW-1:0] mst_addr,
  input  logic [N*PW-1:0] prio_word,
  output logic [N-1:0]    grant,
  output logic            grant_valid
);
  import arb_pkg::*;

  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  qual_w;
  logic [N-1:0]  cand_w;
  logic [N-1:0]  pick_oh_w;
  logic [IW-1:0] pick_idx_w;
  logic          pick_any_w;

  arb_state_e    state_q;
  logic [N-1:0]  grant_q;
  logic [IW-1:0] owner_q;
  logic [IW-1:0] ptr_q;

  arb_req_qual #(.N(N), .AW(AW), .SW(SW), .SLAVE_ID(SLAVE_ID)) u_qual (
    .req       (mst_req),
    .addr_flat (mst_addr),
    .qual      (qual_w)
  );

  arb_level_filter #(.N(N), .PW(PW)) u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .qual      (qual_w),
    .prio_word (prio_word),
    .cand      (cand_w)
  );

  arb_rr_pick #(.N(N)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand      (cand_w),
    .start_idx (ptr_q),
    .pick_oh   (pick_oh_w),
    .pick_idx  (pick_idx_w),
    .pick_any  (pick_any_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_FREE;
      grant_q <= '0;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (state_q == ARB_HELD) begin
      if (!mst_cyc[owner_q]) begin
        state_q <= ARB_FREE;
        grant_q <= '0;
      end
    end else if (pick_any_w) begin
      state_q <= ARB_HELD;
      grant_q <= pick_oh_w;
      owner_q <= pick_idx_w;
      ptr_q   <= (pick_idx_w == IW'(N-1)) ? '0 : pick_idx_w + 1'b1;
    end
  end

  assign grant       = grant_q;
  assign grant_valid = (state_q == ARB_HELD);

  // R8: one-hot grant, flag consistent with the grant vector
  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));
  assert_valid_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant_q != '0));
  // R5 and R7: nothing moves the grant while the owner's cycle is active
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && ((mst_cyc & grant_q) != '0)) |=> $stable(grant_q));
  // R6: a grant ends in zero, never in a direct hand-over
  assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> (grant_q == $past(grant_q)) || (grant_q == '0));
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && ((mst_cyc & grant_q) == '0)) |=> !grant_valid);
  // R2: a fresh grant always goes to a master whose request matched this slave
  assert_grant_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> ((grant_q & $past(qual_w)) != '0));
endmodule

// File: tb/prio_bus_arbiter_test.sv
`timescale 1ns/1ps
module prio_bus_arbiter_test;
  localparam int N = 8;
  localparam int SID = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   mst_req = '0;
  logic [7:0]   mst_cyc = '0;
  logic [255:0] mst_addr = '0;
  logic [15:0]  prio_word = '0;
  logic [7:0]   grant;
  logic         grant_valid;

  int checks = 0;
  int fails = 0;
  logic [7:0] ref_grant = '0;
  int ref_owner = 0;
  int ref_ptr = 0;

  int beats_left [N];
  int wait_left [N];
  int other_left [N];
  logic mine [N];

  always #2.5 clk = ~clk;

  prio_bus_arbiter #(.SLAVE_ID(SID)) uut (
    .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .mst_cyc(mst_cyc),
    .mst_addr(mst_addr), .prio_word(prio_word),
    .grant(grant), .grant_valid(grant_valid)
  );

  function automatic logic [7:0] qualified();
    logic [7:0] q = '0;
    for (int i = 0; i < N; i++)
      q[i] = mst_req[i] && (mst_addr[i*32+28 +: 4] == 4'(SID));
    return q;
  endfunction

  // Reference step at a rising edge, from R2..R6
  task automatic model_step();
    logic [7:0] q;
    int top;
    int w;
    if (ref_grant != '0) begin
      if (!mst_cyc[ref_owner]) ref_grant = '0;
    end else begin
      q = qualified();
      if (q != '0) begin
        top = 0;
        for (int i = 0; i < N; i++)
          if (q[i] && int'(prio_word[2*i +: 2]) > top) top = int'(prio_word[2*i +: 2]);
        w = -1;
        for (int k = 0; k < N; k++) begin
          int p = (ref_ptr + k) % N;
          if (w < 0 && q[p] && int'(prio_word[2*p +: 2]) == top) w = p;
        end
        ref_grant = 8'(1 << w);
        ref_owner = w;
        ref_ptr = (w + 1) % N;
      end
    end
  endtask

  task automatic check_grant(string tag, logic [7:0] exp);
    checks++;
    if (grant !== exp) begin
      fails++;
      $display("FAIL %s grant actual %h expected %h at %0t", tag, grant, exp, $time);
    end
  endtask

  task automatic check_flag(string tag, logic exp);
    checks++;
    if (grant_valid !== exp || $countones(grant) > 1) begin
      fails++;
      $display("FAIL %s grant_valid actual %b expected %b (grant %h)", tag, grant_valid, exp, grant);
    end
  endtask

  task automatic cycle_();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_grant("R9", ref_grant);
    check_flag("R8", ref_grant != '0);
  endtask

  task automatic set_m(int i, logic on, logic [3:0] sel);
    mst_req[i] = on;
    mst_cyc[i] = on;
    mst_addr[i*32 +: 32] = {sel, 28'(i * 32'h100)};
  endtask

  task automatic all_on(logic [3:0] sel);
    for (int i = 0; i < N; i++) set_m(i, 1'b1, sel);
  endtask

  task automatic release_all();
    mst_req = '0;
    mst_cyc = '0;
    cycle_();
    cycle_();
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check_grant("R1", 8'h00);
    check_flag("R1", 1'b0);
    rst_n = 1'b1;
    cycle_();
    check_grant("R1", 8'h00);

    // R1 / R4: equal levels, rotation begins at master 0
    prio_word = 16'h0000;
    all_on(4'(SID));
    cycle_();
    check_grant("R1", 8'h01);
    set_m(0, 1'b0, 4'(SID));
    cycle_();
    check_grant("R6", 8'h00);
    cycle_();
    check_grant("R4", 8'h02);
    release_all();

    // R2: a request for another slave is ignored
    prio_word = 16'hC000;
    set_m(7, 1'b1, 4'(SID - 1));
    repeat (3) begin
      cycle_();
      check_grant("R2", 8'h00);
    end
    set_m(7, 1'b1, 4'(SID));
    cycle_();
    check_grant("R2", 8'h80);
    release_all();

    // R3: highest level wins (master 2 at level 3)
    prio_word = 16'h0030;
    all_on(4'(SID));
    cycle_();
    check_grant("R3", 8'h04);

    // R5 / R7: level change during a grant does not move it
    prio_word = 16'h3000;
    repeat (3) begin
      cycle_();
      check_grant("R5", 8'h04);
      check_grant("R7", 8'h04);
    end
    set_m(2, 1'b0, 4'(SID));
    cycle_();
    check_grant("R6", 8'h00);
    cycle_();
    check_grant("R7", 8'h40);
    release_all();

    // R4: rotation after master 6
    prio_word = 16'h5555;
    all_on(4'(SID));
    cycle_();
    check_grant("R4", 8'h80);
    set_m(7, 1'b0, 4'(SID));
    cycle_();
    cycle_();
    check_grant("R4", 8'h01);
    set_m(0, 1'b0, 4'(SID));
    cycle_();
    cycle_();
    check_grant("R4", 8'h02);
    release_all();

    // Random traffic against the reference model (R2..R9)
    for (int i = 0; i < N; i++) begin
      beats_left[i] = 0; wait_left[i] = 0; other_left[i] = 0; mine[i] = 1'b0;
    end
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 15) == 0) prio_word = 16'($urandom);
      for (int i = 0; i < N; i++) begin
        if (mst_req[i]) begin
          if (mine[i]) begin
            if (grant[i]) begin
              beats_left[i]--;
              if (beats_left[i] == 0) begin
                set_m(i, 1'b0, 4'(SID));
                wait_left[i] = $urandom_range(0, 6);
              end
            end
          end else begin
            other_left[i]--;
            if (other_left[i] == 0) begin
              set_m(i, 1'b0, 4'(SID));
              wait_left[i] = $urandom_range(0, 6);
            end
          end
        end else if (wait_left[i] > 0) begin
          wait_left[i]--;
        end else if ($urandom_range(0, 1) == 1) begin
          mine[i] = ($urandom_range(0, 3) != 0);
          beats_left[i] = $urandom_range(1, 4);
          other_left[i] = $urandom_range(1, 4);
          set_m(i, 1'b1, mine[i] ? 4'(SID) : 4'($urandom_range(6, 15)));
        end
      end
      cycle_();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule